// File: doc/BRIEF.md
# Periodic and One-Shot Comparator Timer Channel

This block is a single timer channel that watches a free-running main counter supplied from outside and raises a one-cycle expiry strobe when that counter reaches a programmed compare value. It holds the compare value, a period and the writable part of a per-channel configuration word. It also carries a set of read-only capability bits that software may read but cannot change. Interrupt routing, message delivery and bus address decoding live outside the block. Its only result is the expiry strobe.

In one-shot mode a comparator write sets the compare value directly. On every arming, the channel checks whether the target has already gone by, using the last counter value that software read. If it has, the channel fires at once. In periodic mode a comparator write sets the period. It also sets the compare value, but only when a self-clearing value-set bit has been written first. Each expiry advances the compare value by one period. A restart runs a short sequential remainder loop that picks the first multiple of the period lying ahead of the counter. Expiry is held off while that loop runs.

A stop strobe or a low global enable cancels anything pending. A start strobe, a rising global enable, or a comparator write that changes the compare value or the period re-arms the channel. The counter width, the routing-capability field and the capability bits are parameters.

Top module: `tmr_chan`

## Requirements
- R1: In periodic mode (config bit 2 = 1) with the value-set bit (config bit 5) at 0, a comparator write merges the enabled bytes (cmp_be bit b covers data bits 8b+7..8b) into the period. The compare value is left unchanged.
- R2: In periodic mode with value-set at 1, a comparator write loads the merged period into both the period and the compare value. After any comparator write, config bit 5 reads 0.
- R3: In one-shot mode (config bit 2 = 0), a comparator write merges the enabled bytes into the compare value. Any config write that leaves bit 2 at 0 forces the period to 0.
- R4: A re-arm in periodic mode with a nonzero period, and with the compare value at v and the counter at c, sets the compare value to v + (((c − v) mod 2^CW) / p + 1) × p, modulo 2^CW. This takes at most CW + 2 cycles, and no expiry occurs in that time.
- R5: On a one-shot re-arm, if (compare − counter) mod 2^CW is greater than (compare − last_read) mod 2^CW, expiry fires within two cycles without any counter tick.
- R6: A config write merges the enabled bytes (cfg_be bit b covers bits 8b+7..8b) into the writable bits only: 0, 1, 2, 5, 7–11 and 12. Bits 3, 4, 13 and 31:16 are read-only capability bits and keep their value. Bit 6 (narrow mode) and bits 15:14 always read 0.
- R7: After reset, the compare value reads all ones and the period reads 0. The config word reads ROUTE_CAP in bits 31:16, PER_CAP in bit 3, WIDE_CAP in bit 4 and MSG_CAP in bit 13, and 0 everywhere else. The expiry strobe is low.
- R8: While the channel is armed and enabled, a cycle with cnt_tick = 1 and cnt_val equal to the compare value makes expire_o high for exactly the next cycle. In periodic mode with a nonzero period, the same clock edge adds the period to the compare value.
- R9: A stop strobe, or glb_en at 0, cancels any pending expiry. No expiry follows until the channel is re-armed.
- R10: While glb_en is 1, a comparator write that changes the compare value or the period re-arms the channel. A comparator write that leaves both unchanged does not re-arm it.
- R11: When cfg_wr and cmp_wr are high in the same cycle, the comparator write takes effect and the config write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global counting enable; a rising edge re-arms the channel |
| start_pls | input | 1 | Re-arm strobe |
| stop_pls | input | 1 | Cancel strobe |
| cnt_val | input | CW | Current main counter value |
| cnt_tick | input | 1 | Main counter holds a new value this cycle |
| cnt_last_rd | input | CW | Counter value that software last read |
| cfg_wr | input | 1 | Config word write |
| cfg_be | input | 4 | Config byte enables |
| cfg_wdata | input | 32 | Config write data |
| cmp_wr | input | 1 | Comparator write |
| cmp_be | input | CW/8 | Comparator byte enables |
| cmp_wdata | input | CW | Comparator write data |
| cfg_q | output | 32 | Config word readback |
| cmp_q | output | CW | Current compare value |
| period_q | output | CW | Current period |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
The bench sweeps base value, period and counter over wrap-around corners: a counter just past the base, a counter at the top of the range, periods of 1 and of all ones. A catch-up loop with an off-by-one error would land one period too early or too late, or would land on the counter itself. The one-shot past-detection tests put the target on both sides of the last read value. An inverted comparison would either fire spuriously or never fire. Further tests cover byte-masked writes, the self-clearing value-set bit, a write that changes nothing, and cancel by stop or disable. These catch a design that leaks read-only bits, keeps the value-set bit stuck, re-arms on a no-op write, or still expires after a stop.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
   // Config word bit positions
   localparam int unsigned CFG_W      = 32;
   localparam int unsigned B_LEVEL    = 0;
   localparam int unsigned B_IRQEN    = 1;
   localparam int unsigned B_PERIODIC = 2;
   localparam int unsigned B_PERCAP   = 3;
   localparam int unsigned B_WIDECAP  = 4;
   localparam int unsigned B_VALSET   = 5;
   localparam int unsigned B_NARROW   = 6;
   localparam int unsigned B_MSGEN    = 12;
   localparam int unsigned B_MSGCAP   = 13;
   localparam int unsigned RCAP_LO    = 16;

   // Writable bits: 0,1,2,5,7..11,12
   localparam logic [CFG_W-1:0] CFG_RW_MASK = 32'h0000_1FA7;
   // Read-only capability bits: 3,4,13,31:16
   localparam logic [CFG_W-1:0] CFG_RO_MASK = 32'hFFFF_2018;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
   import tmr_chan_pkg::*;
#(
   parameter logic [15:0] ROUTE_CAP = 16'h00F0,
   parameter bit          PER_CAP   = 1'b1,
   parameter bit          MSG_CAP   = 1'b1,
   parameter bit          WIDE_CAP  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [3:0]       be,
   input  logic [CFG_W-1:0] wdata,
   input  logic             valset_clr,
   output logic             leave_per,
   output logic [CFG_W-1:0] cfg_q
);
   localparam logic [CFG_W-1:0] RST_VAL =
      ({ROUTE_CAP, 16'h0000}) |
      (CFG_W'(PER_CAP)  << B_PERCAP) |
      (CFG_W'(WIDE_CAP) << B_WIDECAP) |
      (CFG_W'(MSG_CAP)  << B_MSGCAP);

   logic [CFG_W-1:0] merged;
   logic [CFG_W-1:0] nxt;

   for (genvar b = 0; b < 4; b++) begin : g_byte
      assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : cfg_q[8*b +: 8];
   end

   assign nxt       = (merged & CFG_RW_MASK) | (cfg_q & CFG_RO_MASK);
   assign leave_per = wr & ~nxt[B_PERIODIC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg_q <= RST_VAL;
      else if (wr)         cfg_q <= nxt;
      else if (valset_clr) cfg_q[B_VALSET] <= 1'b0;
   end
endmodule

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs #(
   parameter int unsigned CW = 32,
   localparam int unsigned NB = CW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [NB-1:0] be,
   input  logic [CW-1:0] wdata,
   input  logic          periodic,
   input  logic          valset,
   input  logic          per_clr,
   input  logic          load_en,
   input  logic [CW-1:0] load_val,
   output logic          changed,
   output logic [CW-1:0] cmp_q,
   output logic [CW-1:0] per_q
);
   logic [CW-1:0] m_cmp, m_per, nxt_cmp, nxt_per;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign m_cmp[8*b +: 8] = be[b] ? wdata[8*b +: 8] : cmp_q[8*b +: 8];
      assign m_per[8*b +: 8] = be[b] ? wdata[8*b +: 8] : per_q[8*b +: 8];
   end

   always_comb begin
      nxt_cmp = cmp_q;
      nxt_per = per_q;
      if (wr) begin
         if (periodic) begin
            nxt_per = m_per;
            if (valset) nxt_cmp = m_per;
         end else begin
            nxt_cmp = m_cmp;
         end
      end else begin
         if (load_en) nxt_cmp = load_val;
         if (per_clr) nxt_per = '0;
      end
   end

   assign changed = wr & ((nxt_cmp != cmp_q) | (nxt_per != per_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
         per_q <= '0;
      end else begin
         cmp_q <= nxt_cmp;
         per_q <= nxt_per;
      end
   end
endmodule

// File: rtl/tmr_catchup.sv
module tmr_catchup #(
   parameter int unsigned CW = 32,
   localparam int unsigned IW = $clog2(CW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] cmp,
   input  logic [CW-1:0] per,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] nxt
);
   logic [CW-1:0] dvd, rem, cnt_s, per_s;
   logic [IW-1:0] idx;
   logic [CW:0]   r2, r_sub;
   logic          ge;
   logic [CW-1:0] r_new;

   // One restoring step of (cnt - cmp) mod per
   assign r2    = {rem, dvd[CW-1]};
   assign r_sub = r2 - {1'b0, per_s};
   assign ge    = r2 >= {1'b0, per_s};
   assign r_new = ge ? r_sub[CW-1:0] : r2[CW-1:0];

   // cmp + (q+1)*per equals cnt - rem + per
   assign nxt = cnt_s - rem + per_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         dvd   <= '0;
         rem   <= '0;
         cnt_s <= '0;
         per_s <= '0;
         idx   <= '0;
      end else if (abort) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         dvd   <= cnt - cmp;
         rem   <= '0;
         cnt_s <= cnt;
         per_s <= per;
         idx   <= IW'(CW);
      end else if (busy) begin
         rem <= r_new;
         dvd <= dvd << 1;
         idx <= idx - IW'(1);
         if (idx == IW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end else begin
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int unsigned CW        = 32,
   parameter logic [15:0] ROUTE_CAP = 16'h00F0,
   parameter bit          PER_CAP   = 1'b1,
   parameter bit          MSG_CAP   = 1'b1,
   parameter bit          WIDE_CAP  = 1'b0,
   localparam int unsigned NB       = CW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en,
   input  logic             start_pls,
   input  logic             stop_pls,
   input  logic [CW-1:0]    cnt_val,
   input  logic             cnt_tick,
   input  logic [CW-1:0]    cnt_last_rd,
   input  logic             cfg_wr,
   input  logic [3:0]       cfg_be,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             cmp_wr,
   input  logic [NB-1:0]    cmp_be,
   input  logic [CW-1:0]    cmp_wdata,
   output logic [CFG_W-1:0] cfg_q,
   output logic [CW-1:0]    cmp_q,
   output logic [CW-1:0]    period_q,
   output logic             expire_o
);
   if (CW < 8 || (CW % 8) != 0) begin : g_bad_cw
      $error("tmr_chan: CW must be a nonzero multiple of 8");
   end

   logic cfg_we, leave_per, cmp_changed;
   logic en_q, armed, rearm_q, expire_q;
   logic cancel, rearm_req, per_live, past, match;
   logic cu_start, cu_busy, cu_done;
   logic load_en;
   logic [CW-1:0] cu_nxt, load_val;

   assign cfg_we = cfg_wr & ~cmp_wr;   // comparator write wins (R11)

   tmr_cfg_reg #(
      .ROUTE_CAP(ROUTE_CAP), .PER_CAP(PER_CAP),
      .MSG_CAP(MSG_CAP), .WIDE_CAP(WIDE_CAP)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_we), .be(cfg_be), .wdata(cfg_wdata),
      .valset_clr(cmp_wr), .leave_per(leave_per), .cfg_q(cfg_q)
   );

   tmr_cmp_regs #(.CW(CW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .be(cmp_be), .wdata(cmp_wdata),
      .periodic(cfg_q[B_PERIODIC]), .valset(cfg_q[B_VALSET]),
      .per_clr(leave_per), .load_en(load_en), .load_val(load_val),
      .changed(cmp_changed), .cmp_q(cmp_q), .per_q(period_q)
   );

   assign cancel    = stop_pls | ~glb_en;
   assign rearm_req = ~cancel & (start_pls | ~en_q | cmp_changed);
   assign per_live  = cfg_q[B_PERIODIC] & (period_q != '0);
   assign past      = (cmp_q - cnt_val) > (cmp_q - cnt_last_rd);
   assign cu_start  = rearm_q & ~cancel & per_live;
   assign match     = armed & ~cu_busy & ~cu_done & ~rearm_q & ~cancel &
                      cnt_tick & (cnt_val == cmp_q);

   tmr_catchup #(.CW(CW)) u_cu (
      .clk(clk), .rst_n(rst_n), .start(cu_start), .abort(cancel),
      .cnt(cnt_val), .cmp(cmp_q), .per(period_q),
      .busy(cu_busy), .done(cu_done), .nxt(cu_nxt)
   );

   assign load_en  = ~cancel & ~rearm_q & (cu_done | (match & per_live));
   assign load_val = cu_done ? cu_nxt : cmp_q + period_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         armed    <= 1'b0;
         rearm_q  <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         en_q <= glb_en;
         if (cancel) begin
            armed    <= 1'b0;
            rearm_q  <= 1'b0;
            expire_q <= 1'b0;
         end else begin
            rearm_q  <= rearm_req;
            expire_q <= 1'b0;
            if (rearm_q) begin
               armed <= ~per_live;
               if (!per_live && past) expire_q <= 1'b1;
            end else if (cu_done) begin
               armed <= 1'b1;
            end else if (match) begin
               expire_q <= 1'b1;
            end
         end
      end
   end

   assign expire_o = expire_q;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
   import tmr_chan_pkg::*;
#(
   parameter int unsigned CW = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_en,
   input logic             stop_pls,
   input logic             cfg_wr,
   input logic             cmp_wr,
   input logic [CFG_W-1:0] cfg_q,
   input logic [CW-1:0]    cmp_q,
   input logic [CW-1:0]    period_q,
   input logic             expire_o
);
   assert_stop_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pls |=> !expire_o);

   assert_disable_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> !expire_o);

   assert_valset_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !cfg_q[B_VALSET]);

   assert_ro_bits_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> ((cfg_q & CFG_RO_MASK) == ($past(cfg_q) & CFG_RO_MASK)));

   assert_narrow_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !cfg_q[B_NARROW]);

   assert_oneshot_no_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[B_PERIODIC] |-> (period_q == '0));

   assert_period_write_keeps_cmp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_wr && !glb_en && cfg_q[B_PERIODIC] && !cfg_q[B_VALSET]) |=> $stable(cmp_q));
endmodule

bind tmr_chan tmr_chan_chk #(.CW(CW)) chk_i (
   .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .stop_pls(stop_pls),
   .cfg_wr(cfg_wr), .cmp_wr(cmp_wr), .cfg_q(cfg_q), .cmp_q(cmp_q),
   .period_q(period_q), .expire_o(expire_o)
);

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;
   localparam int unsigned CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          glb_en = 1'b0, start_pls = 1'b0, stop_pls = 1'b0;
   logic [CW-1:0] cnt_val = '0, cnt_last_rd = '0;
   logic          cnt_tick = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [3:0]    cfg_be = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          cmp_wr = 1'b0;
   logic [1:0]    cmp_be = '0;
   logic [CW-1:0] cmp_wdata = '0;
   logic [31:0]   cfg_q;
   logic [CW-1:0] cmp_q, period_q;
   logic          expire_o;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   tmr_chan #(.CW(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .start_pls(start_pls),
      .stop_pls(stop_pls), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
      .cnt_last_rd(cnt_last_rd), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cmp_wr(cmp_wr), .cmp_be(cmp_be),
      .cmp_wdata(cmp_wdata), .cfg_q(cfg_q), .cmp_q(cmp_q),
      .period_q(period_q), .expire_o(expire_o)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wcfg(input logic [3:0] be, input logic [31:0] d);
      cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
      cyc();
      cfg_wr = 1'b0;
   endtask

   task automatic wcmp(input logic [1:0] be, input logic [CW-1:0] d);
      cmp_wr = 1'b1; cmp_be = be; cmp_wdata = d;
      cyc();
      cmp_wr = 1'b0;
   endtask

   task automatic count_exp(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         cyc();
         if (expire_o) c++;
      end
   endtask

   task automatic tick_to(input logic [CW-1:0] v);
      cnt_val = v; cnt_tick = 1'b1;
      cyc();
      cnt_tick = 1'b0;
   endtask

   task automatic pulse_start();
      start_pls = 1'b1; cyc(); start_pls = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_pls = 1'b1; cyc(); stop_pls = 1'b0;
   endtask

   int unsigned vlist [3] = '{32'h0010, 32'hFFF0, 32'h8000};
   int unsigned plist [5] = '{32'h0001, 32'h0003, 32'h0100, 32'h7FFF, 32'hFFFF};
   int unsigned clist [4] = '{32'h0000, 32'h0011, 32'h1234, 32'hFFFF};

   initial begin
      int c;
      for (int i = 0; i < 3; i++) cyc();
      rst_n = 1'b1;
      cyc();

      // R7 reset state
      chk("R7 cfg reset", cfg_q, 32'h00F0_2008);
      chk("R7 cmp reset", cmp_q, 16'hFFFF);
      chk("R7 period reset", period_q, 16'h0000);
      chk("R7 expire reset", expire_o, 1'b0);

      // R6 writable/read-only split
      wcfg(4'hF, 32'hFFFF_FFFF);
      chk("R6 all-ones write", cfg_q, 32'h00F0_3FAF);
      wcfg(4'hF, 32'h0000_0000);
      chk("R6 zero write", cfg_q, 32'h00F0_2008);
      wcfg(4'h1, 32'hFFFF_FFFF);
      chk("R6 byte0 only", cfg_q, 32'h00F0_20AF);
      wcfg(4'hF, 32'h0000_0000);

      // R1 periodic write without value-set
      wcfg(4'hF, 32'h0000_0004);
      wcmp(2'b11, 16'h0040);
      chk("R1 period loaded", period_q, 16'h0040);
      chk("R1 cmp unchanged", cmp_q, 16'hFFFF);

      // R2 value-set path and self-clear
      wcfg(4'hF, 32'h0000_0024);
      chk("R2 valset set", cfg_q, 32'h00F0_202C);
      wcmp(2'b01, 16'h0080);
      chk("R2 period via valset", period_q, 16'h0080);
      chk("R2 cmp via valset", cmp_q, 16'h0080);
      chk("R2 valset cleared", cfg_q, 32'h00F0_200C);
      wcmp(2'b10, 16'h1200);
      chk("R1 period byte1", period_q, 16'h1280);
      chk("R1 cmp kept", cmp_q, 16'h0080);

      // R3 leave periodic, one-shot byte writes
      wcfg(4'hF, 32'h0000_0000);
      chk("R3 period forced zero", period_q, 16'h0000);
      wcmp(2'b01, 16'h00AB);
      chk("R3 oneshot byte0", cmp_q, 16'h00AB);
      wcmp(2'b10, 16'h5500);
      chk("R3 oneshot byte1", cmp_q, 16'h55AB);

      // R11 simultaneous writes
      cfg_wr = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'h0000_0004;
      cmp_wr = 1'b1; cmp_be = 2'b11; cmp_wdata = 16'h1234;
      cyc();
      cfg_wr = 1'b0; cmp_wr = 1'b0;
      chk("R11 cfg dropped", cfg_q, 32'h00F0_2008);
      chk("R11 cmp taken", cmp_q, 16'h1234);

      // R8 one-shot expiry on equality tick
      wcmp(2'b11, 16'h0100);
      cnt_val = 16'h0050; cnt_last_rd = 16'h0050;
      glb_en = 1'b1;
      count_exp(4, c);
      chk("R5 future target no fire", c, 0);
      tick_to(16'h00FF);
      chk("R8 no fire off-value", expire_o, 1'b0);
      cnt_val = 16'h0100; cyc();
      chk("R8 no fire without tick", expire_o, 1'b0);
      tick_to(16'h0100);
      chk("R8 fire on match", expire_o, 1'b1);
      cyc();
      chk("R8 single cycle", expire_o, 1'b0);

      // R5 past detection
      cnt_val = 16'h0200; cnt_last_rd = 16'h0050;
      pulse_start();
      count_exp(3, c);
      chk("R5 past fires at once", c, 1);
      cnt_last_rd = 16'h0200;
      pulse_start();
      count_exp(3, c);
      chk("R5 not past no fire", c, 0);

      // R10 rearm on change only
      cnt_last_rd = 16'h0050;
      wcmp(2'b11, 16'h0150);
      count_exp(3, c);
      chk("R10 change rearms", c, 1);
      wcmp(2'b11, 16'h0150);
      count_exp(3, c);
      chk("R10 same write no rearm", c, 0);

      // R9 stop and disable cancel
      wcmp(2'b11, 16'h0300);
      count_exp(3, c);
      chk("R9 armed quietly", c, 0);
      pulse_stop();
      tick_to(16'h0300);
      chk("R9 stop cancels", expire_o, 1'b0);
      pulse_start();
      count_exp(3, c);
      chk("R9 restart quiet", c, 0);
      tick_to(16'h0300);
      chk("R9 restart fires", expire_o, 1'b1);
      glb_en = 1'b0; cyc();
      tick_to(16'h0300);
      chk("R9 disable cancels", expire_o, 1'b0);

      // R4 catch-up sweep
      foreach (vlist[vi]) foreach (plist[pi]) foreach (clist[ci]) begin
         int unsigned v, p, cc, d, e, e2;
         v = vlist[vi]; p = plist[pi]; cc = clist[ci];
         d  = (cc - v) & 32'hFFFF;
         e  = (v + (d / p + 1) * p) & 32'hFFFF;
         e2 = (e + p) & 32'hFFFF;
         glb_en = 1'b0; cyc();
         wcfg(4'hF, 32'h0000_0024);
         wcmp(2'b11, v[15:0]);
         wcmp(2'b11, p[15:0]);
         cnt_val = cc[15:0];
         glb_en = 1'b1;
         count_exp(CW + 8, c);
         chk("R4 no expiry during catch-up", c, 0);
         chk("R4 catch-up compare", cmp_q, e[15:0]);
         tick_to(e[15:0]);
         chk("R8 periodic fire", expire_o, 1'b1);
         chk("R8 periodic advance", cmp_q, e2[15:0]);
      end
      glb_en = 1'b0; cyc();

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule